// File: doc/BRIEF.md
# Oscillator Phase, Reset Qualification and Idle Controller

This block sits between the raw oscillator and a small 8-bit controller core. A divide-by-two stage turns the oscillator into an internal phase signal, so the internal timing does not depend on the oscillator's duty cycle. Each state is two oscillator clocks long, and six states make one machine cycle of twelve oscillator clocks. A one-clock strobe marks the last oscillator clock of every machine cycle.

The external reset pin is active high. It passes through a synchroniser and is then qualified in whole machine cycles. The internal reset is raised only once the pin has stayed high across at least two complete machine cycles. A short pulse on the pin is dropped.

The CPU can request idle mode. In idle mode the CPU clock enable is withheld while the peripheral clock enable keeps running. Idle ends on any enabled interrupt request, which takes effect at a machine-cycle boundary, or on a qualified reset. Entering or leaving idle never raises the internal reset, so register and RAM contents survive.

There is no data stream at this block's edge: every pin is a plain control level or strobe, with no valid/ready handshake and no back-pressure.

A separate active-low power-on clear (`por_n`) puts every register into a known state.

Top module: `clk_reset_idle_ctl`

## Requirements
- R1: `phase_o` toggles on every oscillator clock after `por_n` is released, starting at 0. `per_ce_o` is high exactly when `phase_o` is high, so it pulses once every two clocks, in idle as well.
- R2: `mc_stb_o` is high for exactly one clock out of every twelve. It is high on the sixth `phase_o`-high clock counted from the power-on clear, and on every twelfth clock after that.
- R3: Once `rst_pin` has been high through the two-flop synchroniser at three consecutive machine-cycle boundaries, `int_rst_o` rises on the clock after the third of those boundaries. This guarantees at least two full machine cycles of high level.
- R4: If the synchronised pin goes low before that count completes, the count restarts from zero and `int_rst_o` stays low. A high pulse of 20 clocks never produces a reset.
- R5: `int_rst_o` falls on the clock after the first machine-cycle boundary at which the synchronised pin is low.
- R6: A high `idle_req` sampled while running and not in reset stops `cpu_ce_o` from the next clock on. `per_ce_o` is unaffected.
- R7: `idle_req` has no effect while `int_rst_o` is high.
- R8: Any set bit of `irq_pend` while idle ends idle at the next machine-cycle boundary, or at the current clock if that clock is the boundary. A one-clock request is remembered until then, and `cpu_ce_o` resumes on the following `phase_o`-high clocks.
- R9: A qualified reset clears idle on the same edge on which `int_rst_o` rises. Idle entry and interrupt wake never raise `int_rst_o`.
- R10: After `int_rst_o` falls, idle is clear and `cpu_ce_o` and `per_ce_o` both pulse on every `phase_o`-high clock.
- R11: While `por_n` is low, all outputs are 0 and all state is cleared at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on clear |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| idle_req | input | 1 | Idle entry request from the CPU |
| irq_pend | input | IRQ_W | Enabled interrupt requests, one bit each |
| phase_o | output | 1 | Divide-by-two phase |
| mc_stb_o | output | 1 | Last-clock-of-machine-cycle strobe |
| int_rst_o | output | 1 | Qualified internal reset |
| cpu_ce_o | output | 1 | CPU clock enable, one pulse per state when running |
| per_ce_o | output | 1 | Peripheral clock enable, one pulse per state |

## Verification
The hardest case to reach is a reset pin that rises and falls relative to the machine-cycle boundaries, so that the qualification count sits just below its threshold. It is equally hard to land a one-clock interrupt pulse in the middle of a machine cycle while idle. The stimulus holds the pin for 20 clocks, which can span at most two boundaries, and for 40 clocks, which must span three. It sends single-clock interrupt and idle pulses, and issues an idle request during reset. A behavioural cycle model tracks the boundary position on every clock, so each of these cases is judged at its exact clock.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_WAKE = 2'd2
  } cpu_mode_e;
endpackage

// File: rtl/clk_phase_gen.sv
module clk_phase_gen #(
  parameter int STATES = 6
) (
  input  logic clk,
  input  logic por_n,
  output logic phase,
  output logic mc_stb
);
  localparam int SW = (STATES > 1) ? $clog2(STATES) : 1;
  localparam logic [SW-1:0] LAST = SW'(STATES - 1);

  logic          p_q;
  logic [SW-1:0] st_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      p_q  <= 1'b0;
      st_q <= '0;
    end else begin
      p_q <= ~p_q;
      if (p_q) st_q <= (st_q == LAST) ? '0 : st_q + 1'b1;
    end
  end

  assign phase  = p_q;
  assign mc_stb = p_q && (st_q == LAST);

  p_phase_toggles_r1: assert property (@(posedge clk) disable iff (!por_n)
    phase |=> !phase);
  p_phase_rises_r1: assert property (@(posedge clk) disable iff (!por_n)
    !phase |=> phase);
  p_mc_on_phase_r2: assert property (@(posedge clk) disable iff (!por_n)
    mc_stb |-> phase);
  p_mc_single_r2: assert property (@(posedge clk) disable iff (!por_n)
    mc_stb |=> !mc_stb);
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int SYNC = 2,
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic mc_stb,
  output logic int_rst,
  output logic rst_fire
);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL);

  logic [SYNC-1:0] sync_q;
  logic            sync_hi;
  logic [QW-1:0]   qcnt_q;
  logic            irst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], rst_pin};
  end
  assign sync_hi = sync_q[SYNC-1];

  // count boundaries crossed with the pin high; the first one only arms
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       qcnt_q <= '0;
    else if (!sync_hi)                qcnt_q <= '0;
    else if (mc_stb && qcnt_q != QMAX) qcnt_q <= qcnt_q + 1'b1;
  end

  assign rst_fire = mc_stb && sync_hi && (qcnt_q == QMAX);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   irst_q <= 1'b0;
    else if (rst_fire)            irst_q <= 1'b1;
    else if (mc_stb && !sync_hi)  irst_q <= 1'b0;
  end
  assign int_rst = irst_q;

  p_rst_needs_pin_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(int_rst) |-> $past(sync_hi) && $past(mc_stb));
  p_short_pulse_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!sync_hi && !int_rst) |=> !int_rst);
  p_rst_release_r5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(int_rst) |-> $past(mc_stb) && !$past(sync_hi));
endmodule

// File: rtl/idle_ctl.sv
module idle_ctl
  import clkrst_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             phase,
  input  logic             mc_stb,
  input  logic             int_rst,
  input  logic             rst_fire,
  input  logic             idle_req,
  input  logic [IRQ_W-1:0] irq_pend,
  output logic             cpu_ce,
  output logic             per_ce
);
  cpu_mode_e mode_q;
  logic      any_irq;

  assign any_irq = |irq_pend;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mode_q <= MODE_RUN;
    else if (int_rst || rst_fire) mode_q <= MODE_RUN;
    else begin
      unique case (mode_q)
        MODE_RUN:  if (idle_req) mode_q <= MODE_IDLE;
        MODE_IDLE: if (any_irq)  mode_q <= mc_stb ? MODE_RUN : MODE_WAKE;
        MODE_WAKE: if (mc_stb)   mode_q <= MODE_RUN;
        default:                 mode_q <= MODE_RUN;
      endcase
    end
  end

  assign cpu_ce = phase && (mode_q == MODE_RUN);
  assign per_ce = phase;

  p_cpu_gated_r6: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q != MODE_RUN) |-> !cpu_ce);
  p_idle_blocked_r7: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |=> mode_q == MODE_RUN);
  p_wake_on_boundary_r8: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q == MODE_RUN && $past(mode_q != MODE_RUN) && !$past(int_rst) && !$past(rst_fire))
      |-> $past(mc_stb));
  p_rst_clears_idle_r9: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> mode_q == MODE_RUN);
  p_idle_no_rst_r9: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q == MODE_RUN && idle_req && !int_rst && !rst_fire) |=> !int_rst);
endmodule

// File: rtl/clk_reset_idle_ctl.sv
module clk_reset_idle_ctl #(
  parameter int STATES = 6,
  parameter int SYNC   = 2,
  parameter int QUAL   = 2,
  parameter int IRQ_W  = 4
) (
  input  logic             clk_osc,
  input  logic             por_n,
  input  logic             rst_pin,
  input  logic             idle_req,
  input  logic [IRQ_W-1:0] irq_pend,
  output logic             phase_o,
  output logic             mc_stb_o,
  output logic             int_rst_o,
  output logic             cpu_ce_o,
  output logic             per_ce_o
);
  logic phase, mc_stb, int_rst, rst_fire;

  clk_phase_gen #(.STATES(STATES)) u_phase (
    .clk(clk_osc), .por_n(por_n), .phase(phase), .mc_stb(mc_stb)
  );

  rst_qualifier #(.SYNC(SYNC), .QUAL(QUAL)) u_rstq (
    .clk(clk_osc), .por_n(por_n), .rst_pin(rst_pin), .mc_stb(mc_stb),
    .int_rst(int_rst), .rst_fire(rst_fire)
  );

  idle_ctl #(.IRQ_W(IRQ_W)) u_idle (
    .clk(clk_osc), .por_n(por_n), .phase(phase), .mc_stb(mc_stb),
    .int_rst(int_rst), .rst_fire(rst_fire), .idle_req(idle_req),
    .irq_pend(irq_pend), .cpu_ce(cpu_ce_o), .per_ce(per_ce_o)
  );

  assign phase_o   = phase;
  assign mc_stb_o  = mc_stb;
  assign int_rst_o = int_rst;

  p_no_rst_at_por_r11: assert property (@(posedge clk_osc) disable iff (!por_n)
    $rose(por_n) |-> !int_rst_o);
endmodule

// File: tb/sim_clk_reset_idle_ctl.sv
module sim_clk_reset_idle_ctl;
  localparam int IRQ_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n = 1'b0, rst_pin = 1'b0, idle_req = 1'b0;
  logic [IRQ_W-1:0] irq = '0;
  logic phase_o, mc_stb_o, int_rst_o, cpu_ce_o, per_ce_o;

  clk_reset_idle_ctl #(.IRQ_W(IRQ_W)) u0 (
    .clk_osc(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req),
    .irq_pend(irq), .phase_o(phase_o), .mc_stb_o(mc_stb_o),
    .int_rst_o(int_rst_o), .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit saw_rst = 0;

  // behavioural model: tick 0..11 within machine cycle, mode 0 run / 1 idle / 2 wake pending
  int m_tick, m_s1, m_s2, m_q, m_rst, m_mode;
  bit m_mc, m_fire;
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_tick = 0; m_s1 = 0; m_s2 = 0; m_q = 0; m_rst = 0; m_mode = 0;
    end else begin
      m_mc   = (m_tick == 11);
      m_fire = m_mc && (m_s2 != 0) && (m_q == 2);
      if (m_rst != 0 || m_fire) m_mode = 0;
      else if (m_mode == 0) begin if (idle_req) m_mode = 1; end
      else if (m_mode == 1) begin if (irq != 0) m_mode = m_mc ? 0 : 2; end
      else if (m_mc) m_mode = 0;
      if (m_fire) m_rst = 1; else if (m_mc && m_s2 == 0) m_rst = 0;
      if (m_s2 == 0) m_q = 0; else if (m_mc && m_q != 2) m_q++;
      m_s2 = m_s1; m_s1 = int'(rst_pin);
      m_tick = (m_tick + 1) % 12;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (int_rst_o) saw_rst = 1;
    chk(phase_o == (m_tick % 2), "R1 phase", phase_o, m_tick % 2);
    chk(per_ce_o == (m_tick % 2), "R1 R6 per_ce", per_ce_o, m_tick % 2);
    chk(mc_stb_o == (m_tick == 11), "R2 mc_stb", mc_stb_o, int'(m_tick == 11));
    chk(int_rst_o == m_rst, "R3 R4 R5 int_rst", int_rst_o, m_rst);
    chk(cpu_ce_o == ((m_tick % 2) == 1 && m_mode == 0), "R6 R7 R8 R9 R10 cpu_ce",
        cpu_ce_o, int'((m_tick % 2) == 1 && m_mode == 0));
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic count(input int n, output int c_cpu, output int c_per, output int c_mc);
    c_cpu = 0; c_per = 0; c_mc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      c_cpu += cpu_ce_o; c_per += per_ce_o; c_mc += mc_stb_o;
    end
    #1;
  endtask

  task automatic run_all();
    int a, b, c;
    step(3);
    chk({phase_o, mc_stb_o, int_rst_o, cpu_ce_o, per_ce_o} == 5'b0, "R11 por clear",
        {phase_o, mc_stb_o, int_rst_o, cpu_ce_o, per_ce_o}, 0);
    por_n = 1'b1;
    count(48, a, b, c);
    chk(c == 4, "R2 mc count", c, 4);
    chk(a == 24, "R10 cpu_ce count", a, 24);
    // short reset pulse: at most two boundaries
    step(1); saw_rst = 0; rst_pin = 1'b1; step(20); rst_pin = 1'b0; step(30);
    chk(saw_rst == 0, "R4 short pulse", saw_rst, 0);
    // long reset hold with an idle request during reset
    rst_pin = 1'b1; step(40);
    chk(int_rst_o == 1'b1, "R3 reset asserted", int_rst_o, 1);
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    rst_pin = 1'b0; step(16);
    chk(int_rst_o == 1'b0, "R5 reset released", int_rst_o, 0);
    count(12, a, b, c);
    chk(a == 6, "R7 R10 running after reset", a, 6);
    // idle entry
    saw_rst = 0; idle_req = 1'b1; step(1); idle_req = 1'b0;
    count(24, a, b, c);
    chk(a == 0, "R6 cpu_ce idle", a, 0);
    chk(b == 12, "R6 per_ce idle", b, 12);
    idle_req = 1'b1; step(3); idle_req = 1'b0;
    count(5, a, b, c);
    chk(a == 0, "R6 still idle", a, 0);
    // one-clock interrupt wake
    irq = 4'b0100; step(1); irq = '0;
    step(14);
    count(12, a, b, c);
    chk(a == 6, "R8 woke", a, 6);
    chk(saw_rst == 0, "R9 no reset on idle entry or wake", saw_rst, 0);
    // interrupt when running has no effect
    irq = 4'b0001; step(2); irq = '0;
    count(12, a, b, c);
    chk(a == 6, "R8 irq while running", a, 6);
    // reset during idle
    idle_req = 1'b1; step(1); idle_req = 1'b0; step(5);
    rst_pin = 1'b1; step(40);
    chk(int_rst_o == 1'b1, "R9 reset in idle", int_rst_o, 1);
    count(4, a, b, c);
    chk(a == 2, "R9 idle cleared with reset", a, 2);
    rst_pin = 1'b0; step(16);
    count(12, a, b, c);
    chk(a == 6 && !int_rst_o, "R10 both enables after reset", a, 6);
    // power-on clear mid-run
    step(3); por_n = 1'b0; #1;
    chk({phase_o, int_rst_o, cpu_ce_o} == 3'b0, "R11 async clear",
        {phase_o, int_rst_o, cpu_ce_o}, 0);
    step(2); por_n = 1'b1; step(6);
  endtask

  initial begin
    fork
      run_all();
      begin
        wait (cyc > 100000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule